// File: doc/BRIEF.md
# Microsecond Synchronization Timer

This block keeps a 64-bit count of microseconds for a wireless MAC's timing synchronization function. The count advances once for each pulse on a one-microsecond tick input. The tick is made elsewhere from the system clock.

Software sees the timer through 32-bit registers. Two staging registers hold a preset value, one for the lower half and one for the upper half. Writing either staging register never disturbs the running count. A reload happens only when the top bit of the staged upper word falls from 1 to 0. The intended sequence is:

1. Write the lower word.
2. Write the upper word with its top bit set.
3. Write the upper word again with its top bit clear.

Reading the live count also takes two reads. A read of the lower half captures the matching upper half in a shadow register. A following read of the upper half returns that captured value, so the pair forms one consistent 64-bit snapshot. A separate clear input sets the count to zero.

Top module: `usec_sync_timer`

## Requirements
- R1: After `rst_n` is low, the count, the staged words, the shadow and `rd_data` are all zero.
- R2: Each cycle with `tick_us` high, no clear and no reload adds one to the 64-bit count, with carry from bit 31 into bit 32. Without a tick, the count holds.
- R3: A write with `wr_addr` = 0 stages the lower word only and leaves the running count unchanged.
- R4: A write with `wr_addr` = 1 stages the upper word. If bit 31 of the staged upper word was 1 and this write makes it 0, the count is loaded on the next clock edge after the write edge. The loaded value is {1'b0, staged_upper[30:0], staged_lower}, so bit 63 is always loaded as 0.
- R5: The following upper-word writes cause no reload:
  - a write that keeps bit 31 at 0;
  - a write that raises bit 31 from 0 to 1.
- R6: Counting resumes on the cycle right after the reload edge.
- R7: A tick that falls on the reload edge is dropped; the loaded value wins.
- R8: `timer_clr` high at an edge sets the count to zero. It takes priority over a reload or a tick at the same edge, and a reload lost this way does not happen later.
- R9: A read with `rd_addr` = 0 places count[31:0], as it was before that edge, on `rd_data` after the edge. It also copies count[63:32] into the shadow register.
- R10: A read with `rd_addr` = 1 returns the shadow register, not the live upper half. `rd_data` holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| timer_clr | input | 1 | Synchronous clear of the count |
| tick_us | input | 1 | One-cycle pulse each microsecond |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 = staged lower word, 1 = staged upper word |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | Read source: 0 = live lower half, 1 = shadowed upper half |
| rd_data | output | 32 | Registered read data |

## Verification
Each result is due at a fixed point:

| Stimulus | Result due |
|----------|------------|
| Read | `rd_data` is valid one edge after the read edge |
| Tick or clear | Count changes at the same edge |
| Falling upper-word write | Count is loaded one edge after the write edge |

A behavioural reference model advances on every rising edge using the same inputs. Its read value is compared with `rd_data` at every falling edge, so each result is sampled exactly one register stage after its cause.

Directed sequences pin the reload latency with two back-to-back reads. The first read is taken at the load edge and must return the old count; the second must return the loaded value. A reload written together with a clear must never take effect.

// File: rtl/usts_pkg.sv
package usts_pkg;
    // Register select encodings shared by the write and read ports
    localparam logic SEL_LO = 1'b0;
    localparam logic SEL_HI = 1'b1;
endpackage

// File: rtl/usts_stage.sv
module usts_stage #(
    parameter int REG_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    output logic                 load_o,
    output logic [2*REG_W-1:0]   load_val_o
);
    import usts_pkg::*;

    localparam int TOP = REG_W - 1;

    typedef struct packed {
        logic [REG_W-1:0] lo;
        logic [REG_W-1:0] hi;
        logic             msb_prev;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.msb_prev = st_q.hi[TOP];
        if (wr_en) begin
            if (wr_addr == SEL_HI) st_d.hi = wr_data;
            else                   st_d.lo = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_o     = st_q.msb_prev & ~st_q.hi[TOP];
    assign load_val_o = {1'b0, st_q.hi[TOP-1:0], st_q.lo};

    // A reload must come from an upper-word write that cleared the top bit
    assert_reload_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> $past(wr_en && (wr_addr == SEL_HI) && !wr_data[TOP]));

    // A lower-word write never disturbs the staged upper word
    assert_lo_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == SEL_LO)) |=> $stable(st_q.hi));
endmodule

// File: rtl/usts_count.sv
module usts_count #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr)       c_d.cnt = '0;
        else if (load) c_d.cnt = load_val;
        else if (tick) c_d.cnt = c_q.cnt + STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_o = c_q.cnt;

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_o == '0));

    assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (cnt_o == $past(load_val)));

    assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !clr) |=> (cnt_o == $past(cnt_o) + STEP));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load && !clr) |=> $stable(cnt_o));
endmodule

// File: rtl/usts_readout.sv
module usts_readout #(
    parameter int REG_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 rd_addr,
    input  logic [2*REG_W-1:0]   cnt,
    output logic [REG_W-1:0]     rd_data
);
    import usts_pkg::*;

    localparam int CNT_W = 2 * REG_W;

    typedef struct packed {
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] shadow;
    } rdo_t;

    rdo_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rd_en) begin
            if (rd_addr == SEL_LO) begin
                r_d.rd     = cnt[REG_W-1:0];
                r_d.shadow = cnt[CNT_W-1:REG_W];
            end else begin
                r_d.rd = r_q.shadow;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data = r_q.rd;

    assert_read_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == SEL_LO) |=> (rd_data == $past(cnt[REG_W-1:0])));

    assert_read_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == SEL_HI) |=> (rd_data == $past(r_q.shadow)));

    assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/usec_sync_timer.sv
module usec_sync_timer #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timer_clr,
    input  logic             tick_us,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data
);
    localparam int CNT_W = 2 * REG_W;

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt;

    usts_stage #(.REG_W(REG_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .load_o     (load),
        .load_val_o (load_val)
    );

    usts_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (timer_clr),
        .tick     (tick_us),
        .load     (load),
        .load_val (load_val),
        .cnt_o    (cnt)
    );

    usts_readout #(.REG_W(REG_W)) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .cnt     (cnt),
        .rd_data (rd_data)
    );

    // A loaded value never has the top bit set
    assert_load_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !timer_clr) |=> !cnt[CNT_W-1]);
endmodule

// File: tb/usec_sync_timer_test.sv
module usec_sync_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        timer_clr = 1'b0;
    logic        tick_us = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    usec_sync_timer uut (
        .clk(clk), .rst_n(rst_n), .timer_clr(timer_clr), .tick_us(tick_us),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Behavioural reference model
    bit [63:0] m_cnt = '0;
    bit [31:0] m_lo = '0, m_hi = '0, m_sh = '0, m_rd = '0;
    bit        m_prev = 0;

    always @(posedge clk) begin
        bit        pend;
        bit [63:0] nxt;
        if (!rst_n) begin
            m_cnt = '0; m_lo = '0; m_hi = '0; m_sh = '0; m_rd = '0; m_prev = 0;
        end else begin
            pend = m_prev && !m_hi[31];
            if (timer_clr)   nxt = '0;
            else if (pend)   nxt = {1'b0, m_hi[30:0], m_lo};
            else if (tick_us) nxt = m_cnt + 64'd1;
            else             nxt = m_cnt;
            if (rd_en) begin
                if (!rd_addr) begin m_rd = m_cnt[31:0]; m_sh = m_cnt[63:32]; end
                else m_rd = m_sh;
            end
            m_prev = m_hi[31];
            if (wr_en) begin
                if (wr_addr) m_hi = wr_data;
                else         m_lo = wr_data;
            end
            m_cnt = nxt;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R9, R10)
    always @(negedge clk) begin
        if (!done) chk("R9/R10 model compare", rd_data, m_rd);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit a, bit [31:0] v);
        wr_en = 1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(bit a, output bit [31:0] v);
        rd_en = 1; rd_addr = a;
        @(negedge clk);
        rd_en = 0;
        v = rd_data;
    endtask

    task automatic ticks(int n);
        tick_us = 1;
        repeat (n) @(negedge clk);
        tick_us = 0;
    endtask

    initial begin
        bit [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(0, v); chk("R1 reset low", v, 32'h0);
        rd(1, v); chk("R1 reset high", v, 32'h0);
        // R2 counting and holding
        ticks(5);
        rd(0, v); chk("R2 five ticks", v, 32'd5);
        idle(3);
        rd(0, v); chk("R2 hold without tick", v, 32'd5);
        // R3 lower write stages only
        wr(0, 32'h89AB_CDEF); idle(1);
        rd(0, v); chk("R3 low write no reload", v, 32'd5);
        // R5 no reload on steady-0 or rising top bit
        wr(1, 32'h0000_1234); idle(2);
        rd(0, v); chk("R5 msb stays 0", v, 32'd5);
        wr(1, 32'h8000_1234); idle(2);
        rd(0, v); chk("R5 msb rises", v, 32'd5);
        // R4 falling edge reload, one edge after the write edge
        wr(1, 32'h0000_1234);
        rd(0, v); chk("R4 read at load edge old", v, 32'd5);
        rd(0, v); chk("R4 loaded low", v, 32'h89AB_CDEF);
        rd(1, v); chk("R4 loaded high", v, 32'h0000_1234);
        // R4 bit 63 forced to zero
        wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF); wr(1, 32'h7FFF_FFFF); idle(1);
        rd(0, v); chk("R4 all-ones low", v, 32'hFFFF_FFFF);
        rd(1, v); chk("R4 bit63 zero", v, 32'h7FFF_FFFF);
        // R2 carry across halves
        ticks(1);
        rd(0, v); chk("R2 carry low", v, 32'h0);
        rd(1, v); chk("R2 carry high", v, 32'h8000_0000);
        // R6 / R7 tick during reload dropped, counting resumes
        wr(0, 32'h0000_0100); wr(1, 32'h8000_0000);
        tick_us = 1;
        wr(1, 32'h0);
        idle(3);
        tick_us = 0;
        rd(0, v); chk("R6/R7 resume after reload", v, 32'h102);
        rd(1, v); chk("R6 high after reload", v, 32'h0);
        // R8 clear
        ticks(3);
        timer_clr = 1; @(negedge clk); timer_clr = 0;
        rd(0, v); chk("R8 clear", v, 32'h0);
        ticks(2);
        timer_clr = 1; tick_us = 1; @(negedge clk); timer_clr = 0; tick_us = 0;
        rd(0, v); chk("R8 clear beats tick", v, 32'h0);
        wr(0, 32'h55); wr(1, 32'h8000_0000); wr(1, 32'h0);
        timer_clr = 1; @(negedge clk); timer_clr = 0;
        idle(1);
        rd(0, v); chk("R8 clear beats reload low", v, 32'h0);
        rd(1, v); chk("R8 clear beats reload high", v, 32'h0);
        idle(2);
        rd(0, v); chk("R8 reload not deferred", v, 32'h0);
        // R9 / R10 shadow snapshot
        wr(0, 32'hFFFF_FFFF); wr(1, 32'h8000_0001); wr(1, 32'h1); idle(1);
        rd(0, v); chk("R9 snapshot low", v, 32'hFFFF_FFFF);
        ticks(1);
        rd(1, v); chk("R10 shadow not live", v, 32'h1);
        rd(0, v); chk("R9 new low", v, 32'h0);
        rd(1, v); chk("R9 new shadow", v, 32'h2);
        // Mixed random traffic, checked by the model compare
        for (int i = 0; i < 3000; i++) begin
            tick_us   = ($urandom % 3) == 0;
            timer_clr = ($urandom % 60) == 0;
            wr_en     = ($urandom % 6) == 0;
            wr_addr   = $urandom % 2;
            wr_data   = $urandom;
            rd_en     = ($urandom % 2) == 0;
            rd_addr   = $urandom % 2;
            @(negedge clk);
        end
        tick_us = 0; timer_clr = 0; wr_en = 0; rd_en = 0;
        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule